// File: doc/BRIEF.md
# Prioritized transmit buffer controller

This block keeps the control and status byte for each of a small group of outgoing message buffers in a CAN-style controller. It chooses which pending buffer the transmit engine takes next. Software reaches each buffer's control byte through a plain register port. Each byte holds a request bit, a two-bit ordering priority and three result flags: aborted, lost arbitration and bus error.

The block offers one buffer at a time to the engine over a valid/ready pair. The pair carries the buffer index. While that buffer is in flight, no other buffer is offered. The engine reports how the frame ended with a one-cycle done pulse and a two-bit kind code. The block then updates the flags of the buffer in flight. Software may withdraw a request at any time, and the withdrawal is treated as an abort. The ordering priority decides only which buffer is transferred first. The message itself is never touched.

Top module: `txbuf_sched`

## Requirements
- R1: After reset every control byte reads 0x00 and `tx_valid` is low.
- R2: Control byte layout: bit 6 aborted, bit 5 lost arbitration, bit 4 bus error, bit 3 request, bits 1:0 priority (3 highest). Bits 7 and 2 always read 0. A write stores bits 1:0 and never changes bits 6:4 directly.
- R3: Writing a 1 to bit 3 while the request is 0 sets the request and clears that buffer's aborted, lost-arbitration and error flags.
- R4: When no buffer is in flight, `tx_valid` is high exactly when some buffer has its request set. `tx_idx` names the pending buffer with the highest priority. On a tie, the higher index wins.
- R5: A cycle with `tx_valid` and `tx_ready` both high hands the buffer to the engine. From then until the done pulse, `tx_valid` stays low.
- R6: Done kind code 0 (success) clears the in-flight buffer's request and leaves its flags as they were.
- R7: Done kind 1 (lost arbitration) sets bit 5, and kind 2 (bus error) sets bit 4. In both cases the request stays set, so the buffer is offered again.
- R8: Writing 0 to bit 3 of a pending buffer that is not in flight aborts it at once. On the next cycle bit 6 reads 1 and bit 3 reads 0.
- R9: Writing 0 to bit 3 of the in-flight buffer leaves the request set until the done pulse. On a kind 1 or 2 done, the request clears and bit 6 sets. On a kind 0 done, the request clears and bit 6 stays 0. Done kind 3 (engine abort) always clears the request and sets bit 6.
- R10: Writes to an address at or beyond the buffer count change nothing, and such an address reads 0x00. A done pulse while nothing is in flight changes nothing.
- R11: Writing 0 to bit 3 while the request is already 0 is not an abort and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Buffer index for read and write |
| reg_wdata | input | 8 | Write data for the addressed control byte |
| reg_rdata | output | 8 | Control byte of the addressed buffer |
| tx_valid | output | 1 | A buffer is offered to the engine |
| tx_idx | output | AW | Index of the offered buffer |
| tx_ready | input | 1 | Engine accepts the offered buffer |
| done_valid | input | 1 | Engine ends the frame in flight |
| done_kind | input | 2 | 0 success, 1 lost arbitration, 2 bus error, 3 aborted |

## Verification
The bench builds the block with its default three buffers, which gives a two-bit address with one unused code. With three buffers, every combination of pending mask and priority values can be swept: 8 masks times 64 priority sets. For each one, the offered index is compared with a maximum computed in the bench, so every tie pattern is covered. Directed sequences then take one buffer through each done kind, aborts before and during flight, and the ignored writes and done pulses.

// File: rtl/txbuf_sched.sv
module txbuf_sched #(
  parameter int NBUF = 3,
  parameter int AW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          tx_valid,
  output logic [AW-1:0] tx_idx,
  input  logic          tx_ready,
  input  logic          done_valid,
  input  logic [1:0]    done_kind
);

  localparam logic [1:0] K_OK   = 2'd0;
  localparam logic [1:0] K_LARB = 2'd1;
  localparam logic [1:0] K_ERR  = 2'd2;
  localparam logic [1:0] K_ABT  = 2'd3;

  logic [NBUF-1:0] req_q, abt_q, larb_q, err_q, apend_q;
  logic [1:0]      pri_q [NBUF];
  logic            busy_q;
  logic [AW-1:0]   cur_q;

  logic            sel_any;
  logic [AW-1:0]   sel_idx;
  logic [1:0]      sel_pri;
  logic [NBUF-1:0] wr_hit, fly, fin, kill;

  wire launch  = tx_valid & tx_ready;
  wire addr_ok = int'(reg_addr) < NBUF;

  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    sel_pri = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (req_q[i] && !apend_q[i] && (!sel_any || pri_q[i] >= sel_pri)) begin
        sel_any = 1'b1;
        sel_idx = AW'(i);
        sel_pri = pri_q[i];
      end
    end
  end

  assign tx_valid = sel_any & ~busy_q;
  assign tx_idx   = sel_idx;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      wr_hit[i] = reg_we && addr_ok && (reg_addr == AW'(i));
      fly[i]    = (busy_q && cur_q == AW'(i)) || (launch && tx_idx == AW'(i));
      fin[i]    = done_valid && busy_q && (cur_q == AW'(i));
      kill[i]   = wr_hit[i] && !reg_wdata[3] && req_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      abt_q   <= '0;
      larb_q  <= '0;
      err_q   <= '0;
      apend_q <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      for (int i = 0; i < NBUF; i++) pri_q[i] <= '0;
    end else begin
      if (launch) begin
        busy_q <= 1'b1;
        cur_q  <= tx_idx;
      end
      if (done_valid && busy_q) busy_q <= 1'b0;
      for (int i = 0; i < NBUF; i++) begin
        if (wr_hit[i]) begin
          pri_q[i] <= reg_wdata[1:0];
          if (reg_wdata[3] && !req_q[i]) begin
            req_q[i]  <= 1'b1;
            abt_q[i]  <= 1'b0;
            larb_q[i] <= 1'b0;
            err_q[i]  <= 1'b0;
          end else if (kill[i]) begin
            if (fly[i]) apend_q[i] <= 1'b1;
            else begin
              req_q[i] <= 1'b0;
              abt_q[i] <= 1'b1;
            end
          end
        end
        if (fin[i]) begin
          apend_q[i] <= 1'b0;
          case (done_kind)
            K_OK: req_q[i] <= 1'b0;
            K_LARB, K_ERR: begin
              if (done_kind == K_LARB) larb_q[i] <= 1'b1;
              else                     err_q[i]  <= 1'b1;
              if (apend_q[i] || kill[i]) begin
                req_q[i] <= 1'b0;
                abt_q[i] <= 1'b1;
              end
            end
            K_ABT: begin
              req_q[i] <= 1'b0;
              abt_q[i] <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NBUF; i++)
      if (reg_addr == AW'(i))
        reg_rdata = {1'b0, abt_q[i], larb_q[i], err_q[i], req_q[i], 1'b0, pri_q[i]};
  end

endmodule

// File: rtl/txbuf_sched_chk.sv
module txbuf_sched_chk #(
  parameter int NBUF = 3,
  parameter int AW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          tx_valid,
  input logic [AW-1:0] tx_idx,
  input logic          tx_ready,
  input logic          done_valid,
  input logic [1:0]    done_kind,
  input logic [NBUF-1:0] req_q,
  input logic [NBUF-1:0] abt_q,
  input logic          busy_q,
  input logic [AW-1:0] cur_q
);

  wire in_range = int'(reg_addr) < NBUF;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_range |-> (reg_rdata[7] == 1'b0 && reg_rdata[2] == 1'b0));

  a_r4_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> req_q[tx_idx]);

  a_r5_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  a_r5_silent_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !tx_valid);

  a_r3_set_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_range && reg_wdata[3] && !req_q[reg_addr])
    |=> (req_q[$past(reg_addr)] && !abt_q[$past(reg_addr)]));

  a_r6_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && busy_q && done_kind == 2'd0) |=> !req_q[$past(cur_q)]);

  a_r8_idle_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_range && !reg_wdata[3] && req_q[reg_addr]
     && !(busy_q && cur_q == reg_addr)
     && !(tx_valid && tx_ready && tx_idx == reg_addr))
    |=> (abt_q[$past(reg_addr)] && !req_q[$past(reg_addr)]));

endmodule

bind txbuf_sched txbuf_sched_chk #(.NBUF(NBUF), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
  .tx_idx(tx_idx), .tx_ready(tx_ready), .done_valid(done_valid),
  .done_kind(done_kind), .req_q(req_q), .abt_q(abt_q), .busy_q(busy_q),
  .cur_q(cur_q)
);

// File: tb/txbuf_sched_tb.sv
module txbuf_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 3;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tx_valid;
  logic [AW-1:0] tx_idx;
  logic tx_ready = 1'b0;
  logic done_valid = 1'b0;
  logic [1:0] done_kind = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbuf_sched #(.NBUF(NBUF), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_idx(tx_idx), .tx_ready(tx_ready), .done_valid(done_valid),
    .done_kind(done_kind)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    reg_addr = AW'(a);
    #1;
    check(req, int'(reg_rdata), exp);
  endtask

  task automatic accept();
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic done(input int k);
    @(negedge clk);
    done_valid = 1'b1; done_kind = 2'(k);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  function automatic int best(input int m, input int pc);
    int b = -1;
    int bp = 0;
    for (int i = 0; i < NBUF; i++) begin
      int p = (pc >> (2*i)) & 3;
      if (((m >> i) & 1) != 0 && (b < 0 || p >= bp)) begin
        b = i; bp = p;
      end
    end
    return b;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R10 unused address reads zero
    for (int a = 0; a < 4; a++) rd_check("R1", a, 0);
    check("R1 tx_valid", int'(tx_valid), 0);

    // R2 layout: flags and reserved bits not writable
    wr(0, 8'hF7);
    rd_check("R2", 0, 8'h03);
    wr(0, 8'h70);
    rd_check("R2", 0, 8'h00);

    // R4 sweep of pending masks and priorities
    for (int m = 0; m < 8; m++) begin
      for (int pc = 0; pc < 64; pc++) begin
        for (int i = 0; i < NBUF; i++)
          wr(i, (((m >> i) & 1) << 3) | ((pc >> (2*i)) & 3));
        #1;
        check("R4 valid", int'(tx_valid), (m != 0) ? 1 : 0);
        if (m != 0) check("R4 index", int'(tx_idx), best(m, pc));
      end
    end
    for (int i = 0; i < NBUF; i++) wr(i, 0);
    #1;
    check("R8 all cleared", int'(tx_valid), 0);

    // R3 fresh request clears old flags
    for (int i = 0; i < NBUF; i++) wr(i, 8'h0A);
    for (int i = 0; i < NBUF; i++) rd_check("R3", i, 8'h0A);
    wr(0, 8'h02); wr(1, 8'h02);
    rd_check("R8", 0, 8'h42);
    rd_check("R8", 1, 8'h42);

    // R5 handoff, R7 retries, R6 success
    #1; check("R4 offer", int'(tx_idx), 2);
    accept();
    #1; check("R5 quiet", int'(tx_valid), 0);
    done(1);
    rd_check("R7 larb", 2, 8'h2A);
    #1; check("R7 reoffer", int'(tx_valid), 1);
    accept();
    done(2);
    rd_check("R7 err", 2, 8'h3A);
    accept();
    done(0);
    rd_check("R6", 2, 8'h32);
    #1; check("R6 idle", int'(tx_valid), 0);

    // R10 done while idle ignored
    wr(1, 8'h09);
    done(0);
    rd_check("R10 done idle", 1, 8'h09);
    // R10 out-of-range write ignored
    wr(3, 8'h0B);
    rd_check("R10 addr3", 3, 0);
    rd_check("R10 buf1", 1, 8'h09);
    rd_check("R10 buf0", 0, 8'h42);

    // R9 abort in flight completes at done
    accept();
    wr(1, 8'h01);
    rd_check("R9 pending", 1, 8'h09);
    done(1);
    rd_check("R9 larb abort", 1, 8'h61);
    #1; check("R9 not offered", int'(tx_valid), 0);

    // R9 abort in flight but frame succeeds
    wr(1, 8'h09);
    accept();
    wr(1, 8'h01);
    done(0);
    rd_check("R9 ok wins", 1, 8'h01);

    // R9 engine abort
    wr(1, 8'h09);
    accept();
    done(3);
    rd_check("R9 engine abort", 1, 8'h41);

    // R11 clearing an idle request is not an abort
    wr(2, 8'h0B);
    wr(2, 8'h00);
    rd_check("R8", 2, 8'h40);
    wr(2, 8'h08); wr(2, 8'h00);
    wr(2, 8'h08);
    accept(); done(0);
    rd_check("R6", 2, 8'h00);
    wr(2, 8'h01);
    rd_check("R11", 2, 8'h01);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule